// File: doc/BRIEF.md
# Retriggerable Frame Delay Timer

This block counts carrier clock cycles from an external synchronising event. The event is the rising edge of a trigger input that marks the end of a reader's modulation pause. When the count reaches a programmed delay, the block raises a frame-start level. That rising edge tells a serial transmitter to begin a synchronous reply frame. A second programmed value, the period compare, drops the level again.

The counter does not reload by itself. A match on the period compare stops it, and the block then waits idle until the next trigger edge. Each reply is therefore aligned to a received event, not to a free-running period. Software may rewrite the delay at any time. The comparison always uses the current value.

The trigger is asynchronous to the carrier clock. It passes through a synchroniser before its rising edge is detected. This adds a fixed latency, which the delay value can absorb.

Top module: `frame_delay_timer`

## Requirements
- R1: After reset, `frameStart` is low and stays low until a trigger edge has been seen.
- R2: `trigIn` passes through a two-flop synchroniser, and its rising edge is detected after it. With `trigIn` raised between clock edges, the counter holds 0 after the third following rising clock edge.
- R3: `frameStart` goes high one clock after the count equals `delayCount`, that is after the (A+4)th rising edge following the trigger rise. A delay of 0 raises it on the first counted cycle, after the 4th edge.
- R4: `frameStart` goes low one clock after the count equals `periodCount`, after the (C+4)th rising edge following the trigger rise.
- R5: A period match does not restart or reload the counter. The counter holds at the period value and does not wrap, and `frameStart` stays low until the next trigger edge. A trigger held high is a level, not a new edge, and has no effect.
- R6: A trigger edge that arrives while a delay is running restarts the count from 0. If `frameStart` was high, it goes low on that same clock.
- R7: When `periodCount` is less than or equal to `delayCount`, `frameStart` never rises. The period match takes priority over the delay match.
- R8: `delayCount` is compared live. A new value written during a run takes effect at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Carrier clock; the counter advances once per cycle |
| rstN | input | 1 | Active-low reset |
| trigIn | input | 1 | Asynchronous trigger; a rising edge restarts the delay |
| delayCount | input | 16 | Count at which the frame-start level rises |
| periodCount | input | 16 | Count at which the level falls and the counter stops |
| frameStart | output | 1 | Frame-start level for the transmitter |

## Verification
The bench measures the exact clock on which `frameStart` rises and falls, relative to the trigger rise. An off-by-one in the synchroniser, the edge detector or the compare would show up as a shifted edge. It tries a zero delay, and also a period at or below the delay, where a design that lets the delay match win would emit a stray pulse. It retriggers both mid-delay and while the output is high. A design that ignored the second edge, or failed to clear the output, would give a pulse at the wrong time. The bench also holds the trigger high long past the period and changes the delay mid-run. An auto-reloading counter would then pulse again, and a latched delay would rise late.

// File: rtl/fdt_pkg.sv
package fdt_pkg;
  // Strobes from the control unit to the counting datapath
  typedef struct packed {
    logic restart;  // clear counter to zero
    logic advance;  // increment counter
    logic raise;    // set frame-start level
    logic drop;     // clear frame-start level
  } fdtStrobe_t;
endpackage

// File: rtl/fdt_sync_ctrl.sv
module fdt_sync_ctrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               trigIn,
  input  logic               atDelay,
  input  logic               atPeriod,
  output fdt_pkg::fdtStrobe_t strobe,
  output logic               running,
  output logic               trigEdge
);
  logic [SYNC_STAGES-1:0] syncReg;
  logic                   syncPrev;
  logic                   syncOut;

  // Synchroniser chain, length picked by parameter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncReg[0] <= 1'b0;
    else       syncReg[0] <= trigIn;
  end

  for (genvar i = 1; i < SYNC_STAGES; i++) begin : g_sync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) syncReg[i] <= 1'b0;
      else       syncReg[i] <= syncReg[i-1];
    end
  end

  assign syncOut = syncReg[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncPrev <= 1'b0;
    else       syncPrev <= syncOut;
  end

  assign trigEdge = syncOut & ~syncPrev;

  // Run flag: set by trigger edge, cleared when the period match stops the count
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    running <= 1'b0;
    else if (trigEdge)            running <= 1'b1;
    else if (running && atPeriod) running <= 1'b0;
  end

  always_comb begin
    strobe.restart = trigEdge;
    strobe.advance = running & ~atPeriod & ~trigEdge;
    strobe.raise   = running & atDelay & ~atPeriod;
    strobe.drop    = trigEdge | (running & atPeriod);
  end
endmodule

// File: rtl/fdt_count_path.sv
module fdt_count_path #(
  parameter int CNT_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  fdt_pkg::fdtStrobe_t strobe,
  input  logic [CNT_W-1:0]    delayCount,
  input  logic [CNT_W-1:0]    periodCount,
  output logic [CNT_W-1:0]    count,
  output logic                atDelay,
  output logic                atPeriod,
  output logic                frameStart
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               count <= '0;
    else if (strobe.restart) count <= '0;
    else if (strobe.advance) count <= count + ONE;
  end

  assign atDelay  = (count == delayCount);
  assign atPeriod = (count == periodCount);

  // Drop has priority over raise
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             frameStart <= 1'b0;
    else if (strobe.drop)  frameStart <= 1'b0;
    else if (strobe.raise) frameStart <= 1'b1;
  end
endmodule

// File: rtl/frame_delay_timer.sv
module frame_delay_timer #(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             trigIn,
  input  logic [CNT_W-1:0] delayCount,
  input  logic [CNT_W-1:0] periodCount,
  output logic             frameStart
);
  fdt_pkg::fdtStrobe_t strobe;
  logic                atDelay;
  logic                atPeriod;
  logic                running;
  logic                trigEdge;
  logic [CNT_W-1:0]    count;

  fdt_sync_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .trigIn   (trigIn),
    .atDelay  (atDelay),
    .atPeriod (atPeriod),
    .strobe   (strobe),
    .running  (running),
    .trigEdge (trigEdge)
  );

  fdt_count_path #(.CNT_W(CNT_W)) u_path (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .delayCount  (delayCount),
    .periodCount (periodCount),
    .count       (count),
    .atDelay     (atDelay),
    .atPeriod    (atPeriod),
    .frameStart  (frameStart)
  );
endmodule

// File: rtl/fdt_checker.sv
module fdt_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             trigEdge,
  input logic             running,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] delayCount,
  input logic [CNT_W-1:0] periodCount,
  input logic             frameStart
);
  assert_idle_low_R1: assert property (@(posedge clk) disable iff (!rstN)
    !running |-> !frameStart);

  assert_rise_at_delay_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(frameStart) |-> ($past(running) && ($past(count) == $past(delayCount))));

  assert_fall_cause_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(frameStart) |-> ($past(trigEdge) || ($past(count) == $past(periodCount))));

  assert_hold_when_idle_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!running && !trigEdge) |=> $stable(count));

  assert_step_by_one_R5: assert property (@(posedge clk) disable iff (!rstN)
    (running && !trigEdge && (count != periodCount)) |=>
      (CNT_W'(count - $past(count)) == CNT_W'(1)));

  assert_restart_clears_R6: assert property (@(posedge clk) disable iff (!rstN)
    trigEdge |=> (running && (count == '0) && !frameStart));
endmodule

bind frame_delay_timer fdt_checker #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .trigEdge    (trigEdge),
  .running     (running),
  .count       (count),
  .delayCount  (delayCount),
  .periodCount (periodCount),
  .frameStart  (frameStart)
);

// File: tb/frame_delay_timer_tb.sv
`timescale 1ns/1ps
module frame_delay_timer_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        trigIn = 1'b0;
  logic [15:0] delayCount = 16'd0;
  logic [15:0] periodCount = 16'd0;
  logic        frameStart;
  int          checks = 0;
  int          fails = 0;

  always #5 clk = ~clk;

  frame_delay_timer u_dut (
    .clk         (clk),
    .rstN        (rstN),
    .trigIn      (trigIn),
    .delayCount  (delayCount),
    .periodCount (periodCount),
    .frameStart  (frameStart)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic cycle();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic dropTrig(input int n);
    trigIn = 1'b0;
    for (int i = 0; i < n; i++) cycle();
  endtask

  // Raise trigger at a negedge, then find first rise and fall (edge index j)
  task automatic measure(input int a, input int c, input int expRise,
                         input int expFall, input int window,
                         input string rTag, input string fTag);
    int rise = -1;
    int fall = -1;
    int extra = 0;
    delayCount = 16'(a);
    periodCount = 16'(c);
    trigIn = 1'b1;
    for (int j = 1; j <= window; j++) begin
      cycle();
      if (frameStart && rise < 0) rise = j;
      else if (!frameStart && rise >= 0 && fall < 0) fall = j;
      else if (frameStart && fall >= 0) extra++;
    end
    check(rise == expRise, rTag, "rise edge index", rise, expRise);
    check(fall == expFall, fTag, "fall edge index", fall, expFall);
    check(extra == 0, "R5", "high cycles after fall", extra, 0);
    dropTrig(4);
  endtask

  task automatic testReset();
    int highs = 0;
    for (int i = 0; i < 20; i++) begin
      cycle();
      if (frameStart) highs++;
    end
    check(highs == 0, "R1", "high cycles before any trigger", highs, 0);
  endtask

  task automatic testBasic();
    // A=5,C=12, trigger held high across the window (level is no edge)
    measure(5, 12, 9, 16, 90, "R3", "R4");
  endtask

  task automatic testZeroDelay();
    measure(0, 3, 4, 7, 40, "R2", "R4");
  endtask

  task automatic testPriority();
    measure(10, 4, -1, -1, 40, "R7", "R7");
    measure(6, 6, -1, -1, 40, "R7", "R7");
  endtask

  task automatic testRetrigMid();
    int highs = 0;
    delayCount = 16'd20;
    periodCount = 16'd40;
    trigIn = 1'b1;
    for (int i = 0; i < 8; i++) begin
      cycle();
      if (frameStart) highs++;
    end
    trigIn = 1'b0;
    for (int i = 0; i < 4; i++) begin
      cycle();
      if (frameStart) highs++;
    end
    check(highs == 0, "R6", "high before restarted delay", highs, 0);
    measure(20, 40, 24, 44, 80, "R6", "R6");
  endtask

  task automatic testRetrigHigh();
    delayCount = 16'd2;
    periodCount = 16'd30;
    trigIn = 1'b1;
    for (int i = 0; i < 10; i++) cycle();
    check(frameStart == 1'b1, "R3", "level high mid-run", int'(frameStart), 1);
    trigIn = 1'b0;
    for (int i = 0; i < 3; i++) cycle();
    trigIn = 1'b1;
    for (int j = 1; j <= 6; j++) begin
      cycle();
      if (j == 2) check(frameStart == 1'b1, "R6", "high before restart edge", int'(frameStart), 1);
      if (j == 3) check(frameStart == 1'b0, "R6", "cleared on restart edge", int'(frameStart), 0);
      if (j == 5) check(frameStart == 1'b0, "R6", "low before new delay", int'(frameStart), 0);
      if (j == 6) check(frameStart == 1'b1, "R6", "high after new delay", int'(frameStart), 1);
    end
    dropTrig(40);
  endtask

  task automatic testLiveDelay();
    int rise = -1;
    delayCount = 16'd30;
    periodCount = 16'd50;
    trigIn = 1'b1;
    for (int j = 1; j <= 40; j++) begin
      cycle();
      if (j == 10) delayCount = 16'd15;
      if (frameStart && rise < 0) rise = j;
    end
    check(rise == 19, "R8", "rise after live delay change", rise, 19);
    dropTrig(30);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL R1 watchdog expired: actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(frameStart == 1'b0, "R1", "level during reset", int'(frameStart), 0);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testBasic();
    testZeroDelay();
    testPriority();
    testRetrigMid();
    testRetrigHigh();
    testLiveDelay();
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule